// File: doc/BRIEF.md
# Message Queue Pair Engine

This block is the device side of a pair of circular message rings that a host and a device share. Both rings hold fixed-size slots of 32-bit words. The host places requests on the inbound ring. It then writes the new inbound producer index through a small register port. The engine works through every inbound entry up to that index and checks the header word of each one. A well-formed request goes out on a valid/ready command interface. A malformed one becomes a general-event reply, which goes onto the outbound ring. The consumer index the device has reached is exposed to the host as the write-back copy.

Replies and events from the device's command executor come in on a valid/ready reply interface. Each one is stored at the outbound producer index, and that index then advances. An interrupt is raised at the same time. The host drains outbound entries up to the producer index and writes the index it has reached back as the outbound consumer index. That write, when it catches up, clears the interrupt. Queue storage is an internal RAM model. The host writes inbound words through one port and reads outbound words through another.

Top module: `msgq_engine`

## Requirements
- R1: After reset, both producer and consumer indices are zero, `irq` is low, `cmd_valid` is low and `rsp_ready` is high.
- R2: A register write with `reg_sel`=0 sets the inbound producer index, and one with `reg_sel`=1 sets the outbound consumer index. While the inbound producer equals the inbound consumer, no command is offered.
- R3: Header word 0 is word 0 of a slot, with this layout: opcode in bits 11:0, category in bits 15:12, outbound queue ID in bits 23:16, slot count in bits 28:24 and the valid flag in bit 31. A header is well formed when it has the valid flag set, a category of 0 to 3 and a supported opcode. Such an entry is offered on `cmd_msg` (the whole head slot, word n at bits n*32+31:n*32), and it is held stable until `cmd_ready`.
- R4: Consuming an entry advances the inbound consumer index by the slot count, where a count of 0 counts as 1, modulo the depth. An entry is not handled until at least that many slots lie between the consumer and the producer.
- R5: An entry whose valid flag is clear is never offered as a command. It produces a general event instead. That event has word 0 = valid flag set, slot count 1, the entry's queue ID and category, and opcode 0x018. Word 1 holds status 1 and word 2 is a copy of the offending header.
- R6: A valid entry whose opcode lies outside 0x01–0x1B and 0x20–0x2B, or whose category exceeds 3, produces the same general event with status 2.
- R7: An accepted reply is stored whole at the outbound producer slot, and the producer index then increments modulo the depth.
- R8: The outbound ring is full when the producer plus one equals the consumer, modulo the depth. While it is full, `rsp_ready` is low and general events wait.
- R9: Every outbound write sets `irq`. A host write of an outbound consumer index equal to the producer index clears it, unless an outbound write happens in that same cycle.
- R10: When a general event and a reply want the outbound ring in the same cycle, the event is written first and `rsp_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_sel | input | 1 | 0: inbound producer index, 1: outbound consumer index |
| reg_wdata | input | IW | Index value written |
| ib_we | input | 1 | Host write into the inbound ring |
| ib_waddr | input | IW+SW | Inbound word address {slot, word} |
| ib_wdata | input | 32 | Inbound word data |
| ib_ci | output | IW | Inbound consumer index (host-visible write-back) |
| cmd_valid | output | 1 | Well-formed request offered |
| cmd_ready | input | 1 | Command executor takes the request |
| cmd_msg | output | 32*SLOT_WORDS | Head slot of the offered request |
| rsp_valid | input | 1 | Reply or event to post |
| rsp_ready | output | 1 | Reply accepted this cycle |
| rsp_msg | input | 32*SLOT_WORDS | Reply slot contents |
| ob_pi | output | IW | Outbound producer index (host-visible) |
| irq | output | 1 | Interrupt to the host |
| ob_rslot | input | IW | Host read slot in the outbound ring |
| ob_rword | input | SW | Host read word within the slot |
| ob_rdata | output | 32 | Outbound word read data |

## Verification
Two outbound functions can fall in the same cycle. A host acknowledge that matches the producer index can coincide with the posting of a new entry. The bench drives the consumer-index write and a reply in the same cycle. It then expects `irq` to stay high and the producer to have moved on by one. A second pair is also exercised: a malformed inbound header and a pending reply both claim the outbound ring. The bench judges that case by reading back the ring and finding the general event in the earlier slot and the reply in the next one.

// File: rtl/msgq_engine.sv
module msgq_engine #(
  parameter int QDEPTH     = 8,
  parameter int SLOT_WORDS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic                       reg_sel,
  input  logic [$clog2(QDEPTH)-1:0]  reg_wdata,
  input  logic                       ib_we,
  input  logic [$clog2(QDEPTH)+$clog2(SLOT_WORDS)-1:0] ib_waddr,
  input  logic [31:0]                ib_wdata,
  output logic [$clog2(QDEPTH)-1:0]  ib_ci,
  output logic                       cmd_valid,
  input  logic                       cmd_ready,
  output logic [32*SLOT_WORDS-1:0]   cmd_msg,
  input  logic                       rsp_valid,
  output logic                       rsp_ready,
  input  logic [32*SLOT_WORDS-1:0]   rsp_msg,
  output logic [$clog2(QDEPTH)-1:0]  ob_pi,
  output logic                       irq,
  input  logic [$clog2(QDEPTH)-1:0]  ob_rslot,
  input  logic [$clog2(SLOT_WORDS)-1:0] ob_rword,
  output logic [31:0]                ob_rdata
);
  localparam int IW        = $clog2(QDEPTH);
  localparam int SW        = $clog2(SLOT_WORDS);
  localparam int SLOT_BITS = 32 * SLOT_WORDS;
  localparam logic [11:0] EVT_OP = 12'h018;

  logic [31:0]          ib_mem [QDEPTH*SLOT_WORDS];
  logic [SLOT_BITS-1:0] ob_mem [QDEPTH];
  logic [IW-1:0]        ib_pi, ob_ci;

  logic [31:0]  hdr;
  logic [11:0]  h_op;
  logic [3:0]   h_cat;
  logic [4:0]   h_cnt, nslots;
  logic [IW-1:0] ib_avail;
  logic         pending, opc_ok, bad, ob_full, err_go, rsp_go, ob_wr, ib_adv;
  logic [SLOT_BITS-1:0] evt_msg, ob_wdata;

  for (genvar g = 0; g < SLOT_WORDS; g++) begin : g_cmd
    assign cmd_msg[g*32 +: 32] = ib_mem[{ib_ci, SW'(g)}];
  end

  assign hdr      = cmd_msg[31:0];
  assign h_op     = hdr[11:0];
  assign h_cat    = hdr[15:12];
  assign h_cnt    = hdr[28:24];
  assign nslots   = (h_cnt == 5'd0) ? 5'd1 : h_cnt;
  assign ib_avail = ib_pi - ib_ci;
  assign pending  = (ib_avail != '0) && (32'(nslots) <= 32'(ib_avail));
  assign opc_ok   = (h_op >= 12'h001 && h_op <= 12'h01B) ||
                    (h_op >= 12'h020 && h_op <= 12'h02B);
  assign bad      = !hdr[31] || !opc_ok || (h_cat > 4'd3);

  assign ob_full   = IW'(ob_pi + 1'b1) == ob_ci;
  assign cmd_valid = pending && !bad;
  assign err_go    = pending && bad && !ob_full;
  assign rsp_ready = !ob_full && !(pending && bad);
  assign rsp_go    = rsp_valid && rsp_ready;
  assign ob_wr     = err_go || rsp_go;
  assign ib_adv    = (cmd_valid && cmd_ready) || err_go;

  always_comb begin
    evt_msg         = '0;
    evt_msg[31:0]   = {1'b1, 2'b00, 5'd1, hdr[23:16], h_cat, EVT_OP};
    evt_msg[63:32]  = hdr[31] ? 32'd2 : 32'd1;
    evt_msg[95:64]  = hdr;
    ob_wdata        = err_go ? evt_msg : rsp_msg;
  end

  always_ff @(posedge clk) begin
    if (ib_we) ib_mem[ib_waddr] <= ib_wdata;
    if (ob_wr) ob_mem[ob_pi]    <= ob_wdata;
  end

  assign ob_rdata = ob_mem[ob_rslot][ob_rword*32 +: 32];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ib_pi <= '0;
      ib_ci <= '0;
      ob_pi <= '0;
      ob_ci <= '0;
      irq   <= 1'b0;
    end else begin
      if (reg_wr && !reg_sel) ib_pi <= reg_wdata;
      if (reg_wr &&  reg_sel) ob_ci <= reg_wdata;
      if (ib_adv) ib_ci <= ib_ci + IW'(nslots);
      if (ob_wr)  ob_pi <= ob_pi + 1'b1;
      if (ob_wr)
        irq <= 1'b1;
      else if (reg_wr && reg_sel && reg_wdata == ob_pi)
        irq <= 1'b0;
    end
  end

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_msg)); // R3
  AST_CI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_ready) && !err_go |=> $stable(ib_ci)); // R4
  AST_RSP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ready |=> ob_pi == IW'($past(ob_pi) + 1'b1)); // R7
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    ob_full |=> $stable(ob_pi) || !$stable(ob_ci)); // R8
  AST_IRQ_ON_POST: assert property (@(posedge clk) disable iff (!rst_n)
    ob_wr |=> irq); // R9
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !ob_wr && reg_wr && reg_sel && reg_wdata == ob_pi |=> !irq); // R9
  AST_EVT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    err_go |-> !rsp_ready && !cmd_valid); // R10
endmodule

// File: tb/msgq_engine_bench.sv
module msgq_engine_bench;
  localparam int QD = 8;
  localparam int SWD = 4;
  localparam int IW = $clog2(QD);
  localparam int SW = $clog2(SWD);

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_sel = 0;
  logic [IW-1:0] reg_wdata = '0;
  logic ib_we = 0;
  logic [IW+SW-1:0] ib_waddr = '0;
  logic [31:0] ib_wdata = '0;
  logic [IW-1:0] ib_ci, ob_pi;
  logic cmd_valid, cmd_ready = 0, rsp_valid = 0, rsp_ready, irq;
  logic [32*SWD-1:0] cmd_msg, rsp_msg = '0;
  logic [IW-1:0] ob_rslot = '0;
  logic [SW-1:0] ob_rword = '0;
  logic [31:0] ob_rdata;
  int n_chk = 0, n_fail = 0;

  msgq_engine #(.QDEPTH(QD), .SLOT_WORDS(SWD)) u_msgq_engine (
    .clk, .rst_n, .reg_wr, .reg_sel, .reg_wdata, .ib_we, .ib_waddr, .ib_wdata,
    .ib_ci, .cmd_valid, .cmd_ready, .cmd_msg, .rsp_valid, .rsp_ready, .rsp_msg,
    .ob_pi, .irq, .ob_rslot, .ob_rword, .ob_rdata);

  always #10 clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr(bit v, int cnt, int qid, int cat, int op);
    return {v, 2'b00, 5'(cnt), 8'(qid), 4'(cat), 12'(op)};
  endfunction

  task automatic reg_write(bit sel, int val);
    @(negedge clk); reg_wr = 1; reg_sel = sel; reg_wdata = IW'(val);
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic ib_slot(int slot, logic [31:0] h);
    for (int w = 0; w < SWD; w++) begin
      @(negedge clk); ib_we = 1; ib_waddr = {IW'(slot), SW'(w)};
      ib_wdata = (w == 0) ? h : 32'hA000_0000 + 32'(slot * 16 + w);
    end
    @(negedge clk); ib_we = 0;
  endtask

  task automatic ob_word(int slot, int w, output logic [31:0] d);
    ob_rslot = IW'(slot); ob_rword = SW'(w); #1 d = ob_rdata;
  endtask

  task automatic take_cmd();
    cmd_ready = 1; @(negedge clk); cmd_ready = 0;
  endtask

  task automatic post(logic [31:0] tag);
    rsp_msg = {tag + 3, tag + 2, tag + 1, tag}; rsp_valid = 1;
    for (int i = 0; i < 50 && !rsp_ready; i++) @(negedge clk);
    @(negedge clk); rsp_valid = 0;
  endtask

  task automatic check_evt(int slot, logic [31:0] h, int status, string req);
    logic [31:0] d;
    ob_word(slot, 0, d); check(req, d, {1'b1, 2'b00, 5'd1, h[23:16], h[15:12], 12'h018});
    ob_word(slot, 1, d); check(req, d, 32'(status));
    ob_word(slot, 2, d); check(req, d, h);
  endtask

  task automatic t_reset();
    check("R1 ib_ci", 32'(ib_ci), 0);
    check("R1 ob_pi", 32'(ob_pi), 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 cmd_valid", 32'(cmd_valid), 0);
    check("R1 rsp_ready", 32'(rsp_ready), 1);
  endtask

  task automatic t_good();
    logic [31:0] h = hdr(1, 1, 3, 2, 'h06);
    ib_slot(0, h);
    check("R2 empty no cmd", 32'(cmd_valid), 0);
    reg_write(0, 1);
    check("R3 cmd_valid", 32'(cmd_valid), 1);
    check("R3 header", cmd_msg[31:0], h);
    check("R3 word1", cmd_msg[63:32], 32'hA000_0001);
    @(negedge clk); @(negedge clk);
    check("R3 held", 32'(cmd_valid), 1);
    check("R3 held hdr", cmd_msg[31:0], h);
    take_cmd();
    check("R4 ci step1", 32'(ib_ci), 1);
    check("R2 empty again", 32'(cmd_valid), 0);
  endtask

  task automatic t_multi();
    logic [31:0] h = hdr(1, 3, 1, 3, 'h2B);
    ib_slot(1, h);
    reg_write(0, 3);
    check("R4 waits for slots", 32'(cmd_valid), 0);
    reg_write(0, 4);
    check("R4 ready multi", 32'(cmd_valid), 1);
    take_cmd();
    check("R4 ci step3", 32'(ib_ci), 4);
    ib_slot(4, hdr(1, 0, 0, 0, 'h01));
    reg_write(0, 5);
    check("R4 count0 offered", 32'(cmd_valid), 1);
    take_cmd();
    check("R4 count0 as 1", 32'(ib_ci), 5);
  endtask

  task automatic t_invalid();
    logic [31:0] h = hdr(0, 1, 7, 2, 'h05);
    ib_slot(5, h);
    reg_write(0, 6);
    check("R5 not offered", 32'(cmd_valid), 0);
    @(negedge clk);
    check("R5 ci", 32'(ib_ci), 6);
    check("R5 ob_pi", 32'(ob_pi), 1);
    check("R9 irq set", 32'(irq), 1);
    check_evt(0, h, 1, "R5 event");
  endtask

  task automatic t_badop();
    logic [31:0] h6 = hdr(1, 1, 4, 2, 'h1C);
    logic [31:0] h7 = hdr(1, 1, 5, 5, 'h01);
    ib_slot(6, h6);
    ib_slot(7, h7);
    reg_write(0, 0);
    @(negedge clk); @(negedge clk);
    check("R6 ci wraps", 32'(ib_ci), 0);
    check("R6 ob_pi", 32'(ob_pi), 3);
    check_evt(1, h6, 2, "R6 opcode");
    check_evt(2, h7, 2, "R6 category");
  endtask

  task automatic t_reply_full();
    logic [31:0] d;
    reg_write(1, 3);
    check("R9 irq cleared", 32'(irq), 0);
    post(32'h5000_0000);
    check("R7 ob_pi", 32'(ob_pi), 4);
    check("R9 irq on reply", 32'(irq), 1);
    ob_word(3, 0, d); check("R7 word0", d, 32'h5000_0000);
    ob_word(3, 3, d); check("R7 word3", d, 32'h5000_0003);
    for (int i = 0; i < 6; i++) post(32'h6000_0000 + 32'(i * 16));
    check("R8 pi at full", 32'(ob_pi), 2);
    ob_word(1, 0, d); check("R7 wrapped slot", d, 32'h6000_0050);
    rsp_valid = 1;
    check("R8 stalled", 32'(rsp_ready), 0);
    @(negedge clk);
    check("R8 pi held", 32'(ob_pi), 2);
    rsp_valid = 0;
    reg_write(1, 2);
    check("R9 clear at match", 32'(irq), 0);
    check("R8 room again", 32'(rsp_ready), 1);
  endtask

  task automatic t_same_cycle();
    rsp_msg = {4{32'h7777_0000}}; rsp_valid = 1;
    reg_wr = 1; reg_sel = 1; reg_wdata = IW'(2);
    @(negedge clk); rsp_valid = 0; reg_wr = 0;
    check("R9 post beats ack", 32'(irq), 1);
    check("R9 pi moved", 32'(ob_pi), 3);
  endtask

  task automatic t_priority();
    logic [31:0] h = hdr(0, 0, 2, 1, 'h03);
    logic [31:0] d;
    ib_slot(0, h);
    reg_write(0, 1);
    rsp_msg = {4{32'h8888_0000}}; rsp_valid = 1;
    check("R10 reply held off", 32'(rsp_ready), 0);
    for (int i = 0; i < 50 && !rsp_ready; i++) @(negedge clk);
    @(negedge clk); rsp_valid = 0;
    check("R10 pi", 32'(ob_pi), 5);
    check_evt(3, h, 1, "R10 event first");
    ob_word(4, 0, d); check("R10 reply second", d, 32'h8888_0000);
    check("R10 ci", 32'(ib_ci), 1);
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_good();
    t_multi();
    t_invalid();
    t_badop();
    t_reply_full();
    t_same_cycle();
    t_priority();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule